// File: doc/BRIEF.md
# LT Line Activation Controller

This block supervises bring-up and tear-down of a basic-rate digital subscriber line at the line-terminal end. It does not generate any line signal. Instead it tells the transmit path what to send: nothing, the activation tone, an all-ones framed training signal, a framed and superframed training signal, or full traffic. It chooses the signal from local requests, the far-end tone detector, echo-canceller convergence, and the frame and superframe sync indications of the receiver.

Six down-counting timers run from a 1 ms tick input:
- the abort, reply, hold and release supervisors;
- the tone burst;
- the frame-sync loss persistence window.

The supervisor durations are parameters in milliseconds, and a common divisor shrinks them for simulation. The expiry of each supervisor timer is exported as a one-cycle flag, next to the state and the transmit-signal code.

Top module: `lt_link_act`

## Requirements
- R1: After reset the state code is 0 (idle), the transmit code is 0 (quiet) and all four expiry flags are low. No timer runs while the block rests in idle.
- R2: The state codes are 0 idle, 1 alerting, 2 awaiting reply, 3 echo training, 4 framing, 5 active and 6 pending release. The transmit code is 1 (tone) in alerting, 2 (framed all-ones) in echo training, 3 (superframed training) in framing, 4 (traffic) in active, and 0 (quiet) in the other states. The transmit code changes together with the state.
- R3: A local activation request in idle starts the abort timer and enters alerting. Alerting lasts exactly TONE_MS ticks and then moves to awaiting reply, which starts the reply timer.
- R4: In awaiting reply, a received far-end tone stops the reply timer and enters echo training. If the reply timer expires first, the block returns to idle.
- R5: In idle, a received far-end tone with no local request starts the abort timer and enters echo training. When both arrive in the same cycle, the local request wins and the block enters alerting.
- R6: Convergence in echo training enters framing. Superframe sync in framing enters active and stops the abort timer, so the abort timer never fires while the block is active.
- R7: In active, a loss of frame sync that lasts LOSS_MS/SCALE_DIV ticks without a break enters pending release. A shorter loss has no effect.
- R8: A local deactivation request in active enters pending release. Outside active the request is ignored.
- R9: Entering pending release starts the hold and release timers. Expiry of either timer returns the block to idle. A local activation request in pending release enters alerting and restarts the abort timer.
- R10: The abort timer expires T0_MS/SCALE_DIV ticks after its last start. In any state other than idle, its expiry returns the block to idle.
- R11: When the abort timer expires in the same cycle as another transition, the return to idle wins.
- R12: Bit i of the expiry flags is the expiry of supervisor timer i (0 abort, 1 reply, 2 hold, 3 release). Each flag is a single-cycle pulse. Each supervisor timer loads max(1, ms/SCALE_DIV) ticks.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick_i | input | 1 | One-cycle pulse every millisecond |
| act_req_i | input | 1 | Local activation request |
| deact_req_i | input | 1 | Local deactivation request |
| rx_tone_i | input | 1 | Far-end activation tone detected |
| ec_conv_i | input | 1 | Echo canceller converged |
| sf_sync_i | input | 1 | Superframe sync acquired |
| bf_sync_i | input | 1 | Basic frame sync present |
| tx_sel_o | output | 3 | Transmit-signal code |
| state_o | output | 3 | Current state code |
| tmr_exp_o | output | 4 | Supervisor timer expiry pulses |

## Verification
Abort-timer expiry can land in the same clock as superframe sync while the block is framing. Without the priority rule the block would go active in that clock. The bench provokes this case by waiting in framing with superframe sync held low until the abort flag appears, then raising sync for exactly that one cycle. The scoreboard expects a return to idle, after exactly the abort-timer count of ticks since that timer was restarted from pending release.

// File: rtl/lt_act_pkg.sv
`timescale 1ns/1ps
package lt_act_pkg;

    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_ALERT = 3'd1,
        ST_WAIT  = 3'd2,
        ST_TRAIN = 3'd3,
        ST_FRAME = 3'd4,
        ST_UP    = 3'd5,
        ST_DRAIN = 3'd6
    } lnk_state_e;

    typedef enum logic [2:0] {
        TX_QUIET  = 3'd0,
        TX_TONE   = 3'd1,
        TX_TRAIN  = 3'd2,
        TX_SFRAME = 3'd3,
        TX_DATA   = 3'd4
    } tx_sig_e;

    localparam int NTMR    = 6;
    localparam int TM_T0   = 0;
    localparam int TM_T1   = 1;
    localparam int TM_T2   = 2;
    localparam int TM_T3   = 3;
    localparam int TM_TONE = 4;
    localparam int TM_LOSS = 5;

    function automatic tx_sig_e tx_for(input lnk_state_e s);
        case (s)
            ST_ALERT: return TX_TONE;
            ST_TRAIN: return TX_TRAIN;
            ST_FRAME: return TX_SFRAME;
            ST_UP:    return TX_DATA;
            default:  return TX_QUIET;
        endcase
    endfunction

endpackage

// File: rtl/lt_act_tmr.sv
`timescale 1ns/1ps
module lt_act_tmr #(
    parameter int unsigned LOAD = 1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick_i,
    input  logic start_i,
    input  logic stop_i,
    output logic run_o,
    output logic exp_o
);

    localparam int unsigned CW = (LOAD < 2) ? 1 : $clog2(LOAD + 1);

    typedef struct packed {
        logic [CW-1:0] cnt;
        logic          run;
        logic          exp;
    } tmr_t;

    tmr_t tmr_q, tmr_d;

    always_comb begin
        tmr_d     = tmr_q;
        tmr_d.exp = 1'b0;
        if (start_i) begin
            tmr_d.cnt = CW'(LOAD);
            tmr_d.run = 1'b1;
        end else if (stop_i) begin
            tmr_d.run = 1'b0;
        end else if (tmr_q.run && tick_i) begin
            if (tmr_q.cnt == CW'(1)) begin
                tmr_d.run = 1'b0;
                tmr_d.exp = 1'b1;
            end else begin
                tmr_d.cnt = tmr_q.cnt - CW'(1);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) tmr_q <= '0;
        else        tmr_q <= tmr_d;
    end

    assign run_o = tmr_q.run;
    assign exp_o = tmr_q.exp;

    AST_EXP_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        tmr_q.exp |=> !tmr_q.exp); // R12
    AST_START_LOADS: assert property (@(posedge clk) disable iff (!rst_n)
        start_i |=> (tmr_q.run && tmr_q.cnt == CW'(LOAD) && !tmr_q.exp)); // R12
    AST_FROZEN_NO_TICK: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick_i && !start_i) |=> $stable(tmr_q.cnt)); // R12

endmodule

// File: rtl/lt_link_act.sv
`timescale 1ns/1ps
module lt_link_act
    import lt_act_pkg::*;
#(
    parameter int unsigned T0_MS     = 15000,
    parameter int unsigned T1_MS     = 480,
    parameter int unsigned T2_MS     = 40,
    parameter int unsigned T3_MS     = 520,
    parameter int unsigned LOSS_MS   = 480,
    parameter int unsigned TONE_MS   = 3,
    parameter int unsigned SCALE_DIV = 1
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tick_i,
    input  logic       act_req_i,
    input  logic       deact_req_i,
    input  logic       rx_tone_i,
    input  logic       ec_conv_i,
    input  logic       sf_sync_i,
    input  logic       bf_sync_i,
    output logic [2:0] tx_sel_o,
    output logic [2:0] state_o,
    output logic [3:0] tmr_exp_o
);

    function automatic int unsigned scaled(input int unsigned ms);
        int unsigned v;
        v = ms / SCALE_DIV;
        return (v == 0) ? 1 : v;
    endfunction

    function automatic int unsigned load_of(input int idx);
        case (idx)
            TM_T0:   return scaled(T0_MS);
            TM_T1:   return scaled(T1_MS);
            TM_T2:   return scaled(T2_MS);
            TM_T3:   return scaled(T3_MS);
            TM_TONE: return (TONE_MS == 0) ? 1 : TONE_MS;
            default: return scaled(LOSS_MS);
        endcase
    endfunction

    typedef struct packed {
        lnk_state_e state;
        tx_sig_e    tx;
    } fsm_t;

    fsm_t            fsm_q, fsm_d;
    logic [NTMR-1:0] tmr_start, tmr_stop, tmr_run, tmr_exp;

    for (genvar g = 0; g < NTMR; g++) begin : g_tmr
        lt_act_tmr #(.LOAD(load_of(g))) u_tmr (
            .clk     (clk),
            .rst_n   (rst_n),
            .tick_i  (tick_i),
            .start_i (tmr_start[g]),
            .stop_i  (tmr_stop[g]),
            .run_o   (tmr_run[g]),
            .exp_o   (tmr_exp[g])
        );
    end

    always_comb begin
        fsm_d     = fsm_q;
        tmr_start = '0;
        tmr_stop  = '0;
        case (fsm_q.state)
            ST_IDLE: begin
                if (act_req_i) begin
                    fsm_d.state        = ST_ALERT;
                    tmr_start[TM_T0]   = 1'b1;
                    tmr_start[TM_TONE] = 1'b1;
                end else if (rx_tone_i) begin
                    fsm_d.state      = ST_TRAIN;
                    tmr_start[TM_T0] = 1'b1;
                end
            end
            ST_ALERT: begin
                if (tmr_exp[TM_TONE]) begin
                    fsm_d.state      = ST_WAIT;
                    tmr_start[TM_T1] = 1'b1;
                end
            end
            ST_WAIT: begin
                if (rx_tone_i) begin
                    fsm_d.state     = ST_TRAIN;
                    tmr_stop[TM_T1] = 1'b1;
                end else if (tmr_exp[TM_T1]) begin
                    fsm_d.state = ST_IDLE;
                    tmr_stop    = '1;
                end
            end
            ST_TRAIN: begin
                if (ec_conv_i) fsm_d.state = ST_FRAME;
            end
            ST_FRAME: begin
                if (sf_sync_i) begin
                    fsm_d.state     = ST_UP;
                    tmr_stop[TM_T0] = 1'b1;
                end
            end
            ST_UP: begin
                if (tmr_exp[TM_LOSS] || deact_req_i) begin
                    fsm_d.state       = ST_DRAIN;
                    tmr_start[TM_T2]  = 1'b1;
                    tmr_start[TM_T3]  = 1'b1;
                    tmr_stop[TM_LOSS] = 1'b1;
                end else if (bf_sync_i) begin
                    tmr_stop[TM_LOSS] = 1'b1;
                end else if (!tmr_run[TM_LOSS]) begin
                    tmr_start[TM_LOSS] = 1'b1;
                end
            end
            ST_DRAIN: begin
                if (tmr_exp[TM_T2] || tmr_exp[TM_T3]) begin
                    fsm_d.state = ST_IDLE;
                    tmr_stop    = '1;
                end else if (act_req_i) begin
                    fsm_d.state        = ST_ALERT;
                    tmr_start[TM_T0]   = 1'b1;
                    tmr_start[TM_TONE] = 1'b1;
                    tmr_stop[TM_T2]    = 1'b1;
                    tmr_stop[TM_T3]    = 1'b1;
                end
            end
            default: begin
                fsm_d.state = ST_IDLE;
                tmr_stop    = '1;
            end
        endcase
        // abort supervisor overrides any other move in this cycle
        if (tmr_exp[TM_T0] && fsm_q.state != ST_IDLE) begin
            fsm_d.state = ST_IDLE;
            tmr_start   = '0;
            tmr_stop    = '1;
        end
        fsm_d.tx = tx_for(fsm_d.state);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) fsm_q <= '{state: ST_IDLE, tx: TX_QUIET};
        else        fsm_q <= fsm_d;
    end

    assign state_o   = fsm_q.state;
    assign tx_sel_o  = fsm_q.tx;
    assign tmr_exp_o = tmr_exp[TM_T3:TM_T0];

    AST_IDLE_TIMERS_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        (fsm_q.state == ST_IDLE && $past(fsm_q.state) == ST_IDLE) |-> (tmr_run == '0)); // R1
    AST_ALERT_EXIT: assert property (@(posedge clk) disable iff (!rst_n)
        (fsm_q.state == ST_ALERT) |=> (fsm_q.state inside {ST_ALERT, ST_WAIT, ST_IDLE})); // R3
    AST_UP_FROM_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
        (fsm_q.state == ST_UP && $past(fsm_q.state) != ST_UP) |-> ($past(fsm_q.state) == ST_FRAME)); // R6
    AST_UP_NO_ABORT: assert property (@(posedge clk) disable iff (!rst_n)
        (fsm_q.state == ST_UP) |-> !tmr_run[TM_T0]); // R6
    AST_DRAIN_EXIT: assert property (@(posedge clk) disable iff (!rst_n)
        (fsm_q.state == ST_DRAIN) |=> (fsm_q.state inside {ST_DRAIN, ST_IDLE, ST_ALERT})); // R9
    AST_ABORT_TO_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (tmr_exp[TM_T0] && fsm_q.state != ST_IDLE) |=> (fsm_q.state == ST_IDLE)); // R10
    AST_ABORT_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        (tmr_exp[TM_T0] && fsm_q.state == ST_FRAME && sf_sync_i) |=> (fsm_q.state != ST_UP)); // R11

endmodule

// File: tb/tb_lt_link_act.sv
`timescale 1ns/1ps
module tb_lt_link_act;
    import lt_act_pkg::*;

    localparam int T0L   = 30;
    localparam int T1L   = 8;
    localparam int T2L   = 4;
    localparam int TONEL = 3;

    logic clk = 1'b0, rst_n = 1'b0, tick = 1'b0;
    logic act = 1'b0, deact = 1'b0, rxt = 1'b0, ecc = 1'b0, sfs = 1'b0, bfs = 1'b1;
    logic [2:0] tx_sel, st;
    logic [3:0] texp;

    always #5 clk = ~clk;

    lt_link_act #(
        .T0_MS(60), .T1_MS(16), .T2_MS(8), .T3_MS(12),
        .LOSS_MS(10), .TONE_MS(3), .SCALE_DIV(2)
    ) dut (
        .clk(clk), .rst_n(rst_n), .tick_i(tick),
        .act_req_i(act), .deact_req_i(deact), .rx_tone_i(rxt),
        .ec_conv_i(ecc), .sf_sync_i(sfs), .bf_sync_i(bfs),
        .tx_sel_o(tx_sel), .state_o(st), .tmr_exp_o(texp)
    );

    int checks = 0, fails = 0;
    bit done = 1'b0;

    typedef struct {
        logic [2:0] st;
        int         kind;   // 0 none, 1 ticks in prior state, 2 ticks since abort timer start
        int         val;
        string      req;
    } item_t;
    item_t sbq[$];

    task automatic check(input string req, input string what, input int act_v, input int exp_v);
        checks++;
        if (act_v != exp_v) begin
            fails++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act_v, exp_v);
        end
    endtask

    task automatic push(input logic [2:0] s, input int k, input int v, input string r);
        item_t it;
        it.st = s; it.kind = k; it.val = v; it.req = r;
        sbq.push_back(it);
    endtask

    function automatic int exp_tx(input logic [2:0] s);
        case (s)
            3'd1: return 1;
            3'd3: return 2;
            3'd4: return 3;
            3'd5: return 4;
            default: return 0;
        endcase
    endfunction

    // millisecond tick: one cycle in four
    int tph = 0;
    always @(negedge clk) begin
        if (rst_n) begin
            tph  = (tph + 1) % 4;
            tick = (tph == 0);
        end
    end

    // monitor: pops scoreboard on each state change
    logic [2:0] prev_st;
    logic [3:0] prev_exp, seen;
    int dwell, t0c;
    always @(posedge clk) begin : mon
        item_t it;
        #2;
        if (!rst_n) begin
            prev_st = st; prev_exp = '0; seen = '0; dwell = 0; t0c = 0;
        end else begin
            if (tick) begin dwell++; t0c++; end
            if (texp != 0) check("R12", "flag pulse width", int'((texp & prev_exp) != 0), 0);
            seen     = seen | texp;
            prev_exp = texp;
            if (st != prev_st) begin
                if (sbq.size() == 0) begin
                    check("R2", "unexpected state change", int'(st), int'(prev_st));
                end else begin
                    it = sbq.pop_front();
                    check(it.req, "state", int'(st), int'(it.st));
                    if (it.kind == 1) check(it.req, "ticks in prior state", dwell, it.val);
                    if (it.kind == 2) check(it.req, "ticks since abort start", t0c, it.val);
                end
                check("R2", "tx code", int'(tx_sel), exp_tx(st));
                if (prev_st == ST_IDLE || (prev_st == ST_DRAIN && st == ST_ALERT)) t0c = 0;
                dwell   = 0;
                prev_st = st;
            end
        end
    end

    task automatic drive(input bit a, input bit d, input bit r, input bit e, input bit s);
        @(negedge clk);
        act = a; deact = d; rxt = r; ecc = e; sfs = s;
        @(negedge clk);
        act = 0; deact = 0; rxt = 0; ecc = 0; sfs = 0;
    endtask

    task automatic wait_sb();
        int n = 0;
        while (sbq.size() != 0 && n < 3000) begin
            @(negedge clk);
            n++;
        end
    endtask

    task automatic bring_up(input string r);
        push(ST_ALERT, 0, 0, "R3");
        push(ST_WAIT, 1, TONEL, "R3");
        drive(1, 0, 0, 0, 0); wait_sb();
        push(ST_TRAIN, 0, 0, "R4");
        drive(0, 0, 1, 0, 0); wait_sb();
        push(ST_FRAME, 0, 0, "R6");
        drive(0, 0, 0, 1, 0); wait_sb();
        push(ST_UP, 0, 0, r);
        drive(0, 0, 0, 0, 1); wait_sb();
    endtask

    initial begin : wdog
        #1500000;
        if (!done) begin
            checks++; fails++;
            $display("FAIL R2 watchdog actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin : main
        int n;
        repeat (3) @(negedge clk);
        check("R1", "state in reset", int'(st), 0);
        check("R1", "tx in reset", int'(tx_sel), 0);
        check("R1", "flags in reset", int'(texp), 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        check("R1", "state after reset", int'(st), 0);

        // R5 priority, R3 tone length, R4 reply timeout, R12 reply flag
        seen = '0;
        push(ST_ALERT, 0, 0, "R5");
        push(ST_WAIT, 1, TONEL, "R3");
        push(ST_IDLE, 1, T1L, "R4");
        drive(1, 0, 1, 0, 0); wait_sb();
        check("R12", "reply flag seen", int'(seen[1]), 1);

        // R3/R4/R6 path with R8 ignore in training
        push(ST_ALERT, 0, 0, "R3");
        push(ST_WAIT, 1, TONEL, "R3");
        drive(1, 0, 0, 0, 0); wait_sb();
        push(ST_TRAIN, 0, 0, "R4");
        drive(0, 0, 1, 0, 0); wait_sb();
        drive(0, 1, 0, 0, 0);
        repeat (8) @(negedge clk);
        check("R8", "deact ignored in training", int'(st), int'(ST_TRAIN));
        push(ST_FRAME, 0, 0, "R6");
        drive(0, 0, 0, 1, 0); wait_sb();
        push(ST_UP, 0, 0, "R6");
        drive(0, 0, 0, 0, 1); wait_sb();
        seen = '0;
        repeat (200) @(negedge clk);
        check("R6", "still active", int'(st), int'(ST_UP));
        check("R6", "abort flag in active", int'(seen[0]), 0);

        // R7 short loss
        bfs = 1'b0;
        repeat (8) @(negedge clk);
        bfs = 1'b1;
        repeat (40) @(negedge clk);
        check("R7", "short sync loss", int'(st), int'(ST_UP));

        // R8 deactivation, R9 reactivation from pending release
        push(ST_DRAIN, 0, 0, "R8");
        drive(0, 1, 0, 0, 0); wait_sb();
        push(ST_ALERT, 0, 0, "R9");
        push(ST_WAIT, 1, TONEL, "R3");
        drive(1, 0, 0, 0, 0); wait_sb();
        push(ST_TRAIN, 0, 0, "R4");
        drive(0, 0, 1, 0, 0); wait_sb();
        push(ST_FRAME, 0, 0, "R6");
        drive(0, 0, 0, 1, 0); wait_sb();

        // R11 abort expiry coinciding with superframe sync
        push(ST_IDLE, 2, T0L, "R11");
        n = 0;
        while (!texp[0] && n < 3000) begin @(negedge clk); n++; end
        sfs = 1'b1;
        @(negedge clk);
        sfs = 1'b0;
        wait_sb();
        repeat (4) @(negedge clk);
        check("R11", "idle after coincidence", int'(st), int'(ST_IDLE));

        // R7 long loss, R9 hold expiry
        bring_up("R6");
        push(ST_DRAIN, 0, 0, "R7");
        bfs = 1'b0;
        wait_sb();
        push(ST_IDLE, 1, T2L, "R9");
        wait_sb();
        bfs = 1'b1;

        // R5 tone from idle, R10 abort in training
        push(ST_TRAIN, 0, 0, "R5");
        drive(0, 0, 1, 0, 0); wait_sb();
        push(ST_IDLE, 2, T0L, "R10");
        wait_sb();

        repeat (4) @(negedge clk);
        check("R2", "scoreboard drained", sbq.size(), 0);
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule